// File: doc/BRIEF.md
# DMA Hardware Trigger Conditioner

This block holds back one DMA channel until an external hardware event has been seen. A channel engine asks for permission each time it is about to begin a unit of work. The block picks one event line from a vector of trigger inputs by index, passes the lines through a short synchronizer, and detects the configured edge on the chosen line. A detected edge is stored as a single pending hit. When the engine then asks to start a unit of the gated kind, the stored hit is used up and the unit may begin.

The gating level can be set to one of four granularities: a whole block, a repeated block, the load of a linked-list item, or a single or burst beat. A request for a unit of any other kind is passed straight through. The polarity setting can also mask the trigger entirely, which holds every gated unit back. If a hit arrives while an earlier hit is still waiting, the extra hit is lost and a sticky overrun flag is raised. Software clears this flag with a one-cycle clear pulse. After a gated unit is granted, the block will not grant another gated unit until the engine reports that the current one has finished.

Top module: `dma_trig_cond`

## Requirements
- R1: After reset, the overrun flag is 0 and no hit is pending, so a request for a gated unit is refused (`unit_go` = 0).
- R2: With `cfg_pol` = 1 (rising), a 0-to-1 transition on the selected input stores one hit, and the next gated request is granted.
- R3: With `cfg_pol` = 2 (falling), only a 1-to-0 transition on the selected input stores a hit. A rising transition has no effect.
- R4: With `cfg_pol` = 0 (masked), no transition on any input stores a hit, and gated requests stay refused.
- R5: Only the input whose index equals `cfg_sel` (counting from 0) can store a hit. An index at or above the implemented input count acts as a line tied to 0. Pointing `cfg_sel` at an input that is already high produces no hit.
- R6: The unit kinds are encoded as 0 = block, 1 = repeated block, 2 = linked-list item load, and 3 = single/burst beat. A request whose `unit_kind` differs from `cfg_mode` is granted in the same cycle without any hit.
- R7: Only one hit is stored. A granted gated request uses it up at the start of the unit, so a second gated request with no new hit is refused.
- R8: A hit that arrives while one is already pending, and is not used up in that cycle, sets `trig_ovr`. The flag holds until `ovr_clr` is pulsed, and reads 0 in the cycle after the pulse.
- R9: After a gated grant, further gated requests are refused, even with a hit pending, until `unit_done` has been pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | N_TRIG | Asynchronous event lines |
| cfg_sel | input | SEL_W | Index of the event line in use |
| cfg_pol | input | 2 | 0 masked, 1 rising, 2 falling |
| cfg_mode | input | 2 | Unit kind that is gated |
| unit_req | input | 1 | Engine wants to begin a unit |
| unit_kind | input | 2 | Kind of the requested unit |
| unit_go | output | 1 | Permission for the request in the same cycle |
| unit_done | input | 1 | The gated unit in flight has finished |
| ovr_clr | input | 1 | Clears the overrun flag |
| trig_ovr | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach is a hit that is pending while a gated unit is still in flight. To get there, the stimulus grants a gated unit, withholds `unit_done`, and sends a second event edge. It then confirms that the stored hit is refused until completion is reported, and granted afterwards. Overrun is reached by sending two edges with no request between them. Change of selection is tested by pointing the index at a line that is already high.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
   typedef enum logic [1:0] {
      POL_OFF  = 2'd0,
      POL_RISE = 2'd1,
      POL_FALL = 2'd2
   } trig_pol_e;

   typedef enum logic [1:0] {
      UNIT_BLOCK  = 2'd0,
      UNIT_RBLOCK = 2'd1,
      UNIT_LINK   = 2'd2,
      UNIT_BEAT   = 2'd3
   } unit_kind_e;
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
   parameter int N      = 64,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   localparam int LAST = STAGES - 1;

   logic [N-1:0] stg [STAGES];
   logic [N-1:0] prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("trig_sync_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= raw;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stg[LAST];
   end

   assign rise = stg[LAST] & ~prev_q;
   assign fall = ~stg[LAST] & prev_q;
endmodule

// File: rtl/trig_select.sv
module trig_select
   import dma_trig_pkg::*;
#(
   parameter int N     = 64,
   parameter int SEL_W = 6
) (
   input  logic [N-1:0]     rise,
   input  logic [N-1:0]     fall,
   input  logic [SEL_W-1:0] sel,
   input  logic [1:0]       pol,
   output logic             hit
);
   localparam int NSLOT = 1 << SEL_W;

   logic [NSLOT-1:0] rise_x;
   logic [NSLOT-1:0] fall_x;

   if (N > NSLOT) begin : g_bad_width
      $error("trig_select: SEL_W too narrow for N inputs");
   end

   for (genvar j = 0; j < NSLOT; j++) begin : g_slot
      if (j < N) begin : g_live
         assign rise_x[j] = rise[j];
         assign fall_x[j] = fall[j];
      end else begin : g_tied
         assign rise_x[j] = 1'b0;
         assign fall_x[j] = 1'b0;
      end
   end

   always_comb begin
      unique case (trig_pol_e'(pol))
         POL_RISE: hit = rise_x[sel];
         POL_FALL: hit = fall_x[sel];
         default:  hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/trig_hold.sv
module trig_hold (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  logic [1:0] mode,
   input  logic       req,
   input  logic [1:0] kind,
   input  logic       done,
   input  logic       ovr_clr,
   output logic       go,
   output logic       ovr
);
   logic pend_q, busy_q, ovr_q;
   logic gated, take;

   assign gated = req && (kind == mode);
   assign go    = req && ((kind != mode) || (pend_q && !busy_q));
   assign take  = go && gated;
   assign ovr   = ovr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         busy_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         pend_q <= hit || (pend_q && !take);
         busy_q <= take || (busy_q && !done);
         ovr_q  <= (hit && pend_q && !take) || (ovr_q && !ovr_clr);
      end
   end

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ovr_clr) |=> ovr);
   // R8
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_clr && !hit) |=> !ovr);
   // R7
   consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !hit) |=> !(req && kind == mode && go));
   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done && take) |=> 1'b0);
   // R6
   ungated_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && kind != mode) |-> go);
endmodule

// File: rtl/dma_trig_cond.sv
module dma_trig_cond #(
   parameter int N_TRIG      = 64,
   parameter int SEL_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_TRIG-1:0] trig_in,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [1:0]        cfg_pol,
   input  logic [1:0]        cfg_mode,
   input  logic              unit_req,
   input  logic [1:0]        unit_kind,
   output logic              unit_go,
   input  logic              unit_done,
   input  logic              ovr_clr,
   output logic              trig_ovr
);
   logic [N_TRIG-1:0] rise_w, fall_w;
   logic              hit_w;

   if (N_TRIG < 1) begin : g_bad_count
      $error("dma_trig_cond: N_TRIG must be positive");
   end

   trig_sync_edge #(.N(N_TRIG), .STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .raw(trig_in), .rise(rise_w), .fall(fall_w)
   );

   trig_select #(.N(N_TRIG), .SEL_W(SEL_W)) u_sel (
      .rise(rise_w), .fall(fall_w), .sel(cfg_sel), .pol(cfg_pol), .hit(hit_w)
   );

   trig_hold u_hold (
      .clk(clk), .rst_n(rst_n), .hit(hit_w), .mode(cfg_mode),
      .req(unit_req), .kind(unit_kind), .done(unit_done),
      .ovr_clr(ovr_clr), .go(unit_go), .ovr(trig_ovr)
   );

   // R4
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pol == 2'd0) |-> !hit_w);
endmodule

// File: tb/sim_dma_trig_cond.sv
module sim_dma_trig_cond;
   localparam int PERIOD = 10;
   localparam int NT = 40;
   localparam int SW = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NT-1:0] trig_in = '0;
   logic [SW-1:0] cfg_sel = 6'd3;
   logic [1:0] cfg_pol = 2'd1, cfg_mode = 2'd0, unit_kind = 2'd0;
   logic unit_req = 1'b0, unit_done = 1'b0, ovr_clr = 1'b0;
   logic unit_go, trig_ovr;

   int checks = 0, errors = 0;
   bit finished = 1'b0;
   bit exp_q[$];
   string tag_q[$];

   dma_trig_cond #(.N_TRIG(NT), .SEL_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_sel(cfg_sel),
      .cfg_pol(cfg_pol), .cfg_mode(cfg_mode), .unit_req(unit_req),
      .unit_kind(unit_kind), .unit_go(unit_go), .unit_done(unit_done),
      .ovr_clr(ovr_clr), .trig_ovr(trig_ovr)
   );

   always #(PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: pops one expected grant per request cycle
   always @(negedge clk) begin
      if (unit_req && !finished) begin
         if (exp_q.size() == 0) chk(1'b0, "scoreboard empty", 0, 0);
         else begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(unit_go == e, t, unit_go, e);
         end
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic req(input logic [1:0] k, input bit exp, input bit fin, input string tag);
      @(posedge clk); #1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      unit_req = 1'b1;
      unit_kind = k;
      @(posedge clk); #1;
      unit_req = 1'b0;
      if (fin) begin
         unit_done = 1'b1;
         @(posedge clk); #1;
         unit_done = 1'b0;
      end
   endtask

   task automatic pulse(input int idx);
      @(posedge clk); #1;
      trig_in[idx] = 1'b1;
      cyc(4);
      trig_in[idx] = 1'b0;
      cyc(4);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(trig_ovr == 1'b0, "R1 overrun after reset", trig_ovr, 0);
      req(2'd0, 1'b0, 1'b0, "R1 no grant after reset");

      pulse(3);
      req(2'd0, 1'b1, 1'b1, "R2 rising edge grants");
      req(2'd0, 1'b0, 1'b0, "R7 hit consumed");

      req(2'd3, 1'b1, 1'b0, "R6 beat ungated");
      req(2'd1, 1'b1, 1'b0, "R6 repeated block ungated");
      req(2'd2, 1'b1, 1'b0, "R6 link ungated");
      cfg_mode = 2'd3;
      req(2'd3, 1'b0, 1'b0, "R6 beat now gated");
      req(2'd0, 1'b1, 1'b0, "R6 block now ungated");
      pulse(3);
      req(2'd3, 1'b1, 1'b1, "R6 beat gated grant");

      pulse(5);
      req(2'd3, 1'b0, 1'b0, "R5 unselected input");
      cfg_sel = 6'd45;
      pulse(3);
      req(2'd3, 1'b0, 1'b0, "R5 index beyond count");
      trig_in[7] = 1'b1;
      cyc(4);
      cfg_sel = 6'd7;
      cyc(4);
      req(2'd3, 1'b0, 1'b0, "R5 select a high input");
      trig_in[7] = 1'b0;
      cyc(4);
      cfg_sel = 6'd3;

      cfg_pol = 2'd2;
      trig_in[3] = 1'b1;
      cyc(5);
      req(2'd3, 1'b0, 1'b0, "R3 rising ignored");
      trig_in[3] = 1'b0;
      cyc(5);
      req(2'd3, 1'b1, 1'b1, "R3 falling grants");

      cfg_pol = 2'd0;
      pulse(3);
      req(2'd3, 1'b0, 1'b0, "R4 masked");
      cfg_pol = 2'd1;

      pulse(3);
      @(negedge clk);
      chk(trig_ovr == 1'b0, "R8 single hit no overrun", trig_ovr, 0);
      pulse(3);
      @(negedge clk);
      chk(trig_ovr == 1'b1, "R8 overrun set", trig_ovr, 1);
      cyc(3);
      @(negedge clk);
      chk(trig_ovr == 1'b1, "R8 overrun sticky", trig_ovr, 1);
      @(posedge clk); #1;
      ovr_clr = 1'b1;
      @(posedge clk); #1;
      ovr_clr = 1'b0;
      @(negedge clk);
      chk(trig_ovr == 1'b0, "R8 overrun cleared", trig_ovr, 0);
      req(2'd3, 1'b1, 1'b1, "R7 kept hit grants");
      req(2'd3, 1'b0, 1'b0, "R7 only one stored");

      pulse(3);
      req(2'd3, 1'b1, 1'b0, "R9 grant leaves busy");
      pulse(3);
      req(2'd3, 1'b0, 1'b0, "R9 busy blocks pending hit");
      @(posedge clk); #1;
      unit_done = 1'b1;
      @(posedge clk); #1;
      unit_done = 1'b0;
      req(2'd3, 1'b1, 1'b1, "R9 grant after done");

      cyc(3);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 20000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule